// File: doc/BRIEF.md
# Per-Warp Register Scoreboard

This block keeps, for every warp of a SIMT core, a record of which destination registers still have a result in flight. Each warp presents the instruction at the head of its instruction buffer as a candidate (up to three source operands and one destination, each with a valid bit). The block raises a per-warp ready flag only when that candidate has no read-after-write hazard (a valid source is still pending) and no write-after-write hazard (its destination is still pending). The warp scheduler picks only among warps whose flag is high, so hazards are handled by masking candidates rather than by stalling a pipeline.

When the scheduler issues an instruction it reports the warp and destination, and that register becomes pending from the next cycle on. When the writeback stage retires a result it reports the warp and register, and the pending mark is removed. A release takes effect in the cycle it is reported: the candidate check in that cycle already sees the register as free. An attempt to reserve a register that is still pending is flagged on a dedicated error output.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset no register of any warp is pending, so every warp whose candidate has valid operands is reported ready.
- R2: A warp's ready flag is low while any source slot whose valid bit is set names a register pending for that warp.
- R3: A source slot whose valid bit is clear has no effect on the ready flag, whatever register it names.
- R4: A warp's ready flag is low while its candidate's destination valid bit is set and that destination register is pending for that warp.
- R5: An issue with the destination valid bit set makes that register pending for the issuing warp from the next cycle on.
- R6: A writeback makes its register non-pending for its warp, and the ready flags in the same cycle already treat that register as free.
- R7: An issue with the destination valid bit clear reserves no register.
- R8: An issue that reserves a register still pending for that warp (after any same-cycle release) drives the error output high in that cycle, and the register stays pending.
- R9: A writeback and an issue naming the same warp and register in the same cycle leave the register pending and do not raise the error output.
- R10: Reservations, releases and hazard checks of one warp have no effect on any other warp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_src_valid | input | NUM_WARPS*NUM_SRCS | Source slot valid bits; slot s of warp w at bit w*NUM_SRCS+s |
| cand_src_id | input | NUM_WARPS*NUM_SRCS*REG_W | Source register numbers, slot s of warp w at field w*NUM_SRCS+s |
| cand_dst_valid | input | NUM_WARPS | Candidate destination valid, one bit per warp |
| cand_dst_id | input | NUM_WARPS*REG_W | Candidate destination register number, field w per warp |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_warp | input | WARP_W | Warp of the issued instruction |
| issue_dst_valid | input | 1 | The issued instruction writes a register |
| issue_dst_id | input | REG_W | Destination register of the issued instruction |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_warp | input | WARP_W | Warp of the written-back result |
| wb_reg | input | REG_W | Register of the written-back result |
| ready | output | NUM_WARPS | Per-warp hazard-free flag |
| double_reserve_err | output | 1 | Issue targets a register that is still pending |

## Verification
The two functions that can coincide are the release from a writeback and the hazard check or reservation of an issue in the same cycle. The bench provokes this directly: a writeback lands in the same cycle as a candidate that reads the released register (which must be ready in that very cycle), and a writeback and an issue target the same warp and register together (which must leave the register pending and keep the error output low). A behavioural model that applies release before check and reservation is compared with both outputs on every clock, through directed cases and a long random phase where writebacks and issues collide often on a small register window.

// File: rtl/sb_pkg.sv
package sb_pkg;

   localparam int SB_DEF_WARPS = 4;
   localparam int SB_DEF_REGS  = 16;
   localparam int SB_DEF_SRCS  = 3;

   typedef enum logic [1:0] {
      HZ_NONE = 2'd0,
      HZ_RAW  = 2'd1,
      HZ_WAW  = 2'd2,
      HZ_BOTH = 2'd3
   } hazard_e;

endpackage

// File: rtl/sb_reg_decode.sv
module sb_reg_decode #(
   parameter int NUM_REGS = 16,
   localparam int REG_W = $clog2(NUM_REGS)
) (
   input  logic                en,
   input  logic [REG_W-1:0]    id,
   output logic [NUM_REGS-1:0] mask
);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
      assign mask[r] = en && (id == REG_W'(r));
   end

endmodule

// File: rtl/sb_warp_row.sv
module sb_warp_row #(
   parameter int NUM_REGS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] clr_mask,
   input  logic [NUM_REGS-1:0] set_mask,
   output logic [NUM_REGS-1:0] held,
   output logic [NUM_REGS-1:0] eff
);

   // release applies first, so the cleared view is what the checks see
   assign eff = held & ~clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= eff | set_mask;
   end

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
   import sb_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int NUM_SRCS = 3,
   localparam int REG_W = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0]       pend,
   input  logic [NUM_SRCS-1:0]       src_valid,
   input  logic [NUM_SRCS*REG_W-1:0] src_id,
   input  logic                      dst_valid,
   input  logic [REG_W-1:0]          dst_id,
   output hazard_e                   kind
);

   logic [NUM_SRCS-1:0] src_hit;
   logic                raw, waw;

   for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
      assign src_hit[s] = src_valid[s] && pend[src_id[s*REG_W +: REG_W]];
   end

   assign raw = |src_hit;
   assign waw = dst_valid && pend[dst_id];

   always_comb begin
      unique case ({waw, raw})
         2'b00:   kind = HZ_NONE;
         2'b01:   kind = HZ_RAW;
         2'b10:   kind = HZ_WAW;
         default: kind = HZ_BOTH;
      endcase
   end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
   import sb_pkg::*;
#(
   parameter int NUM_WARPS = SB_DEF_WARPS,
   parameter int NUM_REGS  = SB_DEF_REGS,
   parameter int NUM_SRCS  = SB_DEF_SRCS,
   localparam int REG_W  = $clog2(NUM_REGS),
   localparam int WARP_W = $clog2(NUM_WARPS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_WARPS*NUM_SRCS-1:0]       cand_src_valid,
   input  logic [NUM_WARPS*NUM_SRCS*REG_W-1:0] cand_src_id,
   input  logic [NUM_WARPS-1:0]                cand_dst_valid,
   input  logic [NUM_WARPS*REG_W-1:0]          cand_dst_id,
   input  logic                                issue_valid,
   input  logic [WARP_W-1:0]                   issue_warp,
   input  logic                                issue_dst_valid,
   input  logic [REG_W-1:0]                    issue_dst_id,
   input  logic                                wb_valid,
   input  logic [WARP_W-1:0]                   wb_warp,
   input  logic [REG_W-1:0]                    wb_reg,
   output logic [NUM_WARPS-1:0]                ready,
   output logic                                double_reserve_err
);

   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("reg_scoreboard: NUM_WARPS must be at least 2");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("reg_scoreboard: NUM_REGS must be at least 2");
   end
   if (NUM_SRCS < 1) begin : g_bad_srcs
      $error("reg_scoreboard: NUM_SRCS must be at least 1");
   end

   logic [NUM_REGS-1:0]           wb_mask, iss_mask;
   logic [NUM_REGS-1:0]           held_w [NUM_WARPS];
   logic [NUM_REGS-1:0]           eff_w  [NUM_WARPS];
   logic [NUM_WARPS-1:0]          clash_w;
   logic [NUM_WARPS*NUM_REGS-1:0] resv_flat;

   sb_reg_decode #(.NUM_REGS(NUM_REGS)) u_wb_dec (
      .en   (wb_valid),
      .id   (wb_reg),
      .mask (wb_mask)
   );

   sb_reg_decode #(.NUM_REGS(NUM_REGS)) u_iss_dec (
      .en   (issue_valid && issue_dst_valid),
      .id   (issue_dst_id),
      .mask (iss_mask)
   );

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic                wb_sel, iss_sel;
      logic [NUM_REGS-1:0] clr_m, set_m;
      hazard_e             kind;

      assign wb_sel  = (wb_warp == WARP_W'(w));
      assign iss_sel = (issue_warp == WARP_W'(w));
      assign clr_m   = wb_sel  ? wb_mask  : '0;
      assign set_m   = iss_sel ? iss_mask : '0;

      sb_warp_row #(.NUM_REGS(NUM_REGS)) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_mask (clr_m),
         .set_mask (set_m),
         .held     (held_w[w]),
         .eff      (eff_w[w])
      );

      sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_SRCS(NUM_SRCS)) u_chk (
         .pend      (eff_w[w]),
         .src_valid (cand_src_valid[w*NUM_SRCS +: NUM_SRCS]),
         .src_id    (cand_src_id[w*NUM_SRCS*REG_W +: NUM_SRCS*REG_W]),
         .dst_valid (cand_dst_valid[w]),
         .dst_id    (cand_dst_id[w*REG_W +: REG_W]),
         .kind      (kind)
      );

      assign ready[w]   = (kind == HZ_NONE);
      assign clash_w[w] = |(set_m & eff_w[w]);
      assign resv_flat[w*NUM_REGS +: NUM_REGS] = held_w[w];
   end

   assign double_reserve_err = |clash_w;

endmodule

// File: rtl/reg_scoreboard_chk.sv
module reg_scoreboard_chk #(
   parameter int NUM_WARPS = 4,
   parameter int NUM_REGS  = 16,
   parameter int NUM_SRCS  = 3,
   localparam int REG_W  = $clog2(NUM_REGS),
   localparam int WARP_W = $clog2(NUM_WARPS),
   localparam int IDX_W  = $clog2(NUM_WARPS*NUM_REGS)
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic [NUM_WARPS-1:0]                cand_dst_valid,
   input logic [NUM_WARPS*REG_W-1:0]          cand_dst_id,
   input logic                                issue_valid,
   input logic [WARP_W-1:0]                   issue_warp,
   input logic                                issue_dst_valid,
   input logic [REG_W-1:0]                    issue_dst_id,
   input logic                                wb_valid,
   input logic [WARP_W-1:0]                   wb_warp,
   input logic [REG_W-1:0]                    wb_reg,
   input logic [NUM_WARPS-1:0]                ready,
   input logic                                double_reserve_err,
   input logic [NUM_WARPS*NUM_REGS-1:0]       resv_flat
);

   logic [IDX_W-1:0] iss_idx, wb_idx;
   logic             iss_res, same_slot;

   assign iss_idx   = IDX_W'(issue_warp) * IDX_W'(NUM_REGS) + IDX_W'(issue_dst_id);
   assign wb_idx    = IDX_W'(wb_warp) * IDX_W'(NUM_REGS) + IDX_W'(wb_reg);
   assign iss_res   = issue_valid && issue_dst_valid;
   assign same_slot = iss_res && wb_valid && (iss_idx == wb_idx);

   AST_ISSUE_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
      iss_res |=> resv_flat[$past(iss_idx)]); // R5

   AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !same_slot) |=> !resv_flat[$past(wb_idx)]); // R6

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wb_valid && !iss_res) |=> $stable(resv_flat)); // R7

   AST_ERR_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      double_reserve_err |-> iss_res); // R8

   AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      double_reserve_err |=> resv_flat[$past(iss_idx)]); // R8

   AST_SAME_SLOT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      same_slot |-> !double_reserve_err); // R9

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
      logic dst_busy;
      assign dst_busy = cand_dst_valid[w]
         && resv_flat[w*NUM_REGS + int'(cand_dst_id[w*REG_W +: REG_W])]
         && !(wb_valid && wb_warp == WARP_W'(w) && wb_reg == cand_dst_id[w*REG_W +: REG_W]);
      AST_WAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         dst_busy |-> !ready[w]); // R4
   end

endmodule

bind reg_scoreboard reg_scoreboard_chk #(
   .NUM_WARPS (NUM_WARPS),
   .NUM_REGS  (NUM_REGS),
   .NUM_SRCS  (NUM_SRCS)
) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .cand_dst_valid     (cand_dst_valid),
   .cand_dst_id        (cand_dst_id),
   .issue_valid        (issue_valid),
   .issue_warp         (issue_warp),
   .issue_dst_valid    (issue_dst_valid),
   .issue_dst_id       (issue_dst_id),
   .wb_valid           (wb_valid),
   .wb_warp            (wb_warp),
   .wb_reg             (wb_reg),
   .ready              (ready),
   .double_reserve_err (double_reserve_err),
   .resv_flat          (resv_flat)
);

// File: tb/tb_reg_scoreboard.sv
module tb_reg_scoreboard;

   localparam int NW = 4;
   localparam int NR = 16;
   localparam int NS = 3;
   localparam int RW = $clog2(NR);
   localparam int WW = $clog2(NW);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NW*NS-1:0]     cand_src_valid = '0;
   logic [NW*NS*RW-1:0]  cand_src_id = '0;
   logic [NW-1:0]        cand_dst_valid = '0;
   logic [NW*RW-1:0]     cand_dst_id = '0;
   logic                 issue_valid = 1'b0;
   logic [WW-1:0]        issue_warp = '0;
   logic                 issue_dst_valid = 1'b0;
   logic [RW-1:0]        issue_dst_id = '0;
   logic                 wb_valid = 1'b0;
   logic [WW-1:0]        wb_warp = '0;
   logic [RW-1:0]        wb_reg = '0;
   logic [NW-1:0]        ready;
   logic                 double_reserve_err;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R1";
   bit    pend_m [NW][NR];
   bit    done = 1'b0;

   always #2 clk = ~clk;

   reg_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR), .NUM_SRCS(NS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cand_src_valid(cand_src_valid), .cand_src_id(cand_src_id),
      .cand_dst_valid(cand_dst_valid), .cand_dst_id(cand_dst_id),
      .issue_valid(issue_valid), .issue_warp(issue_warp),
      .issue_dst_valid(issue_dst_valid), .issue_dst_id(issue_dst_id),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .ready(ready), .double_reserve_err(double_reserve_err)
   );

   function automatic bit freed(int w, int r);
      return pend_m[w][r] && !(wb_valid && int'(wb_warp) == w && int'(wb_reg) == r);
   endfunction

   function automatic bit exp_ready(int w);
      bit hz = 1'b0;
      for (int s = 0; s < NS; s++)
         if (cand_src_valid[w*NS+s] && freed(w, int'(cand_src_id[(w*NS+s)*RW +: RW]))) hz = 1'b1;
      if (cand_dst_valid[w] && freed(w, int'(cand_dst_id[w*RW +: RW]))) hz = 1'b1;
      return !hz;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_model();
      logic [NW-1:0] er;
      bit ee;
      for (int w = 0; w < NW; w++) er[w] = exp_ready(w);
      ee = issue_valid && issue_dst_valid && freed(int'(issue_warp), int'(issue_dst_id));
      check(cur_req, "ready vector", int'(ready), int'(er));
      check(cur_req, "double_reserve_err", int'(double_reserve_err), int'(ee));
   endtask

   task automatic update_model();
      bit nxt [NW][NR];
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) nxt[w][r] = freed(w, r);
      if (issue_valid && issue_dst_valid) nxt[int'(issue_warp)][int'(issue_dst_id)] = 1'b1;
      pend_m = nxt;
   endtask

   // compare before the edge, update model at the edge, return at negedge
   task automatic tick();
      #1;
      compare_model();
      @(posedge clk);
      update_model();
      @(negedge clk);
   endtask

   task automatic clear_inputs();
      cand_src_valid = '0; cand_src_id = '0; cand_dst_valid = '0; cand_dst_id = '0;
      issue_valid = 1'b0; issue_dst_valid = 1'b0; issue_warp = '0; issue_dst_id = '0;
      wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
   endtask

   task automatic set_src(int w, int s, bit v, int r);
      cand_src_valid[w*NS+s] = v;
      cand_src_id[(w*NS+s)*RW +: RW] = RW'(r);
   endtask

   task automatic set_dst(int w, bit v, int r);
      cand_dst_valid[w] = v;
      cand_dst_id[w*RW +: RW] = RW'(r);
   endtask

   task automatic do_issue(int w, bit dv, int r);
      issue_valid = 1'b1; issue_warp = WW'(w); issue_dst_valid = dv; issue_dst_id = RW'(r);
   endtask

   task automatic do_wb(int w, int r);
      wb_valid = 1'b1; wb_warp = WW'(w); wb_reg = RW'(r);
   endtask

   task automatic expect_ready(string req, int w, bit v);
      #1;
      check(req, $sformatf("ready[%0d]", w), int'(ready[w]), int'(v));
      #(-0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) pend_m[w][r] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything free after reset
      cur_req = "R1";
      for (int w = 0; w < NW; w++) begin set_src(w, 0, 1, w); set_dst(w, 1, w + 8); end
      #1; check("R1", "ready after reset", int'(ready), (1 << NW) - 1);
      check("R1", "err after reset", int'(double_reserve_err), 0);
      tick();
      clear_inputs();

      // R5: issue reserves w0 r5
      cur_req = "R5";
      do_issue(0, 1, 5);
      tick();
      clear_inputs();
      // R2 / R10: w0 reads r5 blocked, w1 reads r5 free
      cur_req = "R2";
      set_src(0, 2, 1, 5); set_src(1, 0, 1, 5);
      #1; check("R2", "ready[0] raw", int'(ready[0]), 0);
      check("R10", "ready[1] other warp", int'(ready[1]), 1);
      tick();
      // R3: invalid slot naming r5 ignored
      cur_req = "R3";
      clear_inputs(); set_src(0, 1, 0, 5); set_src(0, 0, 1, 6);
      #1; check("R3", "ready[0] invalid slot", int'(ready[0]), 1);
      tick();
      // R4: destination r5 pending
      cur_req = "R4";
      clear_inputs(); set_dst(0, 1, 5);
      #1; check("R4", "ready[0] waw", int'(ready[0]), 0);
      tick();
      // R6: same-cycle release visible
      cur_req = "R6";
      clear_inputs(); set_src(0, 1, 1, 5); do_wb(0, 5);
      #1; check("R6", "ready[0] same-cycle release", int'(ready[0]), 1);
      tick();
      clear_inputs(); set_src(0, 1, 1, 5);
      #1; check("R6", "ready[0] after release", int'(ready[0]), 1);
      tick();

      // R7: issue without destination reserves nothing
      cur_req = "R7";
      clear_inputs(); do_issue(2, 0, 3);
      tick();
      clear_inputs(); set_src(2, 0, 1, 3);
      #1; check("R7", "ready[2] no reservation", int'(ready[2]), 1);
      tick();

      // R8: double reservation
      cur_req = "R8";
      clear_inputs(); do_issue(1, 1, 7);
      tick();
      clear_inputs(); do_issue(1, 1, 7);
      #1; check("R8", "err on double reserve", int'(double_reserve_err), 1);
      tick();
      clear_inputs(); set_src(1, 0, 1, 7);
      #1; check("R8", "ready[1] still pending", int'(ready[1]), 0);
      tick();
      clear_inputs(); do_wb(1, 7);
      tick();

      // R9: release and reserve of the same slot together
      cur_req = "R9";
      clear_inputs(); do_issue(3, 1, 2);
      tick();
      clear_inputs(); do_issue(3, 1, 2); do_wb(3, 2);
      #1; check("R9", "err same slot", int'(double_reserve_err), 0);
      tick();
      clear_inputs(); set_src(3, 2, 1, 2);
      #1; check("R9", "ready[3] re-reserved", int'(ready[3]), 0);
      tick();

      // R10: random traffic on a small window, model compared every cycle
      cur_req = "R10";
      for (int i = 0; i < 2000; i++) begin
         clear_inputs();
         for (int w = 0; w < NW; w++) begin
            for (int s = 0; s < NS; s++) set_src(w, s, 1'($urandom_range(1)), $urandom_range(5));
            set_dst(w, 1'($urandom_range(1)), $urandom_range(5));
         end
         if ($urandom_range(2) != 0) do_issue($urandom_range(NW-1), 1'($urandom_range(3) != 0), $urandom_range(5));
         if ($urandom_range(2) != 0) do_wb($urandom_range(NW-1), $urandom_range(5));
         tick();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule